// File: doc/BRIEF.md
# Dual Serial Channel Chaining Controller

This block decides how two FIFO-backed serial channels share one chip's serial resources. A small mode register picks between two ways of working. In the split mode each channel runs on its own pins and its enable goes straight through as its run permission. In the chained mode both channels take turns on the pin interface of channel 0. This lets a long transfer be cut into bursts and played back to back, so that the stream is longer than one FIFO.

In chained mode the controller holds one owner at a time. A channel whose enable rises while the other channel is transferring waits. It is granted in the system clock cycle right after the owner reports completion. That hand-off is far shorter than one serial bit period, so no serial clock period is lost between bursts. The pin select output tells the pin multiplexer which channel drives the shared pins.

The mode register locks itself while any channel is busy or holds a grant. A write made during that time is dropped and raises a sticky error flag. The internals of the serial channels are outside this block.

Top module: `sio_chain_ctrl`

## Requirements
- R1: After reset, cfg_rdata_o reads 8'hFC, go_o is 2'b00, cfg_err_o is 0, chained_o is 0 and pin_sel_o is 0.
- R2: Only mode bits [1:0] take write data. Bits [7:2] of cfg_rdata_o always read as 1, whatever value is written to them.
- R3: Mode code 2'b01 selects chained mode (chained_o=1). Codes 2'b00, 2'b10 and 2'b11 all select split mode (chained_o=0).
- R4: A write made while any busy_i bit is 1, or while a chained grant is held, leaves the mode unchanged and sets cfg_err_o. cfg_err_o stays 1 until reset, including across later accepted writes.
- R5: In split mode go_o equals en_i in the same cycle, with no register delay, and pin_sel_o is 0.
- R6: In chained mode at most one bit of go_o is 1 in any cycle.
- R7: In chained mode with no owner, a single raised enable is granted on the next clock edge.
- R8: In chained mode with no owner, when both enables are raised in the same cycle, channel 0 is granted first.
- R9: In chained mode, when the owner pulses its done_i bit while the other channel's enable is high, the other channel's go_o bit is 1 in the very next cycle.
- R10: In chained mode pin_sel_o equals the index of the granted channel (0 or 1).
- R11: In chained mode, an owner's done_i with no pending request from the other channel returns the controller to no owner (go_o=2'b00) on the next cycle. A done_i pulse from a channel that does not own the pins is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Mode register write strobe |
| cfg_wdata_i | input | 8 | Mode register write data |
| cfg_rdata_o | output | 8 | Mode register read value |
| cfg_err_o | output | 1 | Sticky flag: write made while locked |
| en_i | input | 2 | Per-channel transfer enable |
| busy_i | input | 2 | Per-channel transfer in progress |
| done_i | input | 2 | Per-channel transfer completion pulse |
| go_o | output | 2 | Per-channel run permission |
| chained_o | output | 1 | Chained mode active |
| pin_sel_o | output | 1 | Channel routed to the shared pins |

## Verification
On every cycle, the assertions check four things: the single-owner rule, the hand-off and release transitions after the owner's done pulse, the channel 0 priority for requests that arrive together, and that a locked write leaves the mode unchanged while the error flag stays set. Other behaviours can only be shown by the bench's scenarios. These are the register read value with its fixed upper bits, how the unused mode codes decode, the same-cycle pass-through in split mode, and a done pulse from the non-owner being ignored. The bench checks them by driving a chained-mode sequence table and then directed cases.

// File: rtl/sio_chain_pkg.sv
package sio_chain_pkg;
   localparam int NCH = 2;

   typedef enum logic [1:0] {
      OWN_NONE = 2'd0,
      OWN_CH0  = 2'd1,
      OWN_CH1  = 2'd2
   } owner_t;

   function automatic logic mode_is_chained(input logic [1:0] code);
      return code == 2'b01;
   endfunction
endpackage

// File: rtl/sio_chain_mode_reg.sv
module sio_chain_mode_reg
   import sio_chain_pkg::*;
#(
   parameter int REG_W  = 8,
   parameter int MODE_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [REG_W-1:0] wdata_i,
   input  logic             lock_i,
   output logic [REG_W-1:0] rdata_o,
   output logic             err_o,
   output logic             chained_o
);
   localparam int FILL_W = REG_W - MODE_W;

   generate
      if (MODE_W != 2) begin : g_bad_mode_w
         $error("MODE_W must be 2");
      end
      if (REG_W <= MODE_W) begin : g_bad_reg_w
         $error("REG_W must exceed MODE_W");
      end
   endgenerate

   logic [MODE_W-1:0] mode_q;
   logic              err_q;
   logic              unused_hi;

   assign unused_hi = ^wdata_i[REG_W-1:MODE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         err_q  <= 1'b0;
      end else if (we_i) begin
         if (lock_i) err_q  <= 1'b1;
         else        mode_q <= wdata_i[MODE_W-1:0];
      end
   end

   assign rdata_o   = {{FILL_W{1'b1}}, mode_q};
   assign err_o     = err_q;
   assign chained_o = mode_is_chained(mode_q);

   // R4: a locked write must not touch the mode
   assert_locked_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && lock_i) |=> $stable(rdata_o));
   // R4: error flag is sticky
   assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);
endmodule

// File: rtl/sio_chain_arbiter.sv
module sio_chain_arbiter
   import sio_chain_pkg::*;
#(
   parameter int PRIO_CH = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           active_i,
   input  logic [NCH-1:0] req_i,
   input  logic [NCH-1:0] done_i,
   output logic [NCH-1:0] grant_o,
   output logic           held_o,
   output logic           sel_o
);
   generate
      if (PRIO_CH < 0 || PRIO_CH >= NCH) begin : g_bad_prio
         $error("PRIO_CH out of range");
      end
   endgenerate

   owner_t state_q, state_d, both_pick;

   generate
      if (PRIO_CH == 0) begin : g_prio_ch0
         assign both_pick = OWN_CH0;
      end else begin : g_prio_ch1
         assign both_pick = OWN_CH1;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      if (!active_i) begin
         state_d = OWN_NONE;
      end else begin
         unique case (state_q)
            OWN_NONE: begin
               if (&req_i)        state_d = both_pick;
               else if (req_i[0]) state_d = OWN_CH0;
               else if (req_i[1]) state_d = OWN_CH1;
            end
            OWN_CH0: if (done_i[0]) state_d = req_i[1] ? OWN_CH1 : OWN_NONE;
            OWN_CH1: if (done_i[1]) state_d = req_i[0] ? OWN_CH0 : OWN_NONE;
            default: state_d = OWN_NONE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= OWN_NONE;
      else        state_q <= state_d;
   end

   assign grant_o = {state_q == OWN_CH1, state_q == OWN_CH0};
   assign held_o  = state_q != OWN_NONE;
   assign sel_o   = state_q == OWN_CH1;

   // R9: waiting channel takes over right after the owner's done
   assert_handoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && state_q == OWN_CH0 && done_i[0] && req_i[1]) |=> grant_o == 2'b10);
   assert_handoff_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && state_q == OWN_CH1 && done_i[1] && req_i[0]) |=> grant_o == 2'b01);
   // R11: release when nothing is pending
   assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && state_q == OWN_CH0 && done_i[0] && !req_i[1]) |=> grant_o == 2'b00);
   // R8: simultaneous requests from idle go to the priority channel
   assert_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && state_q == OWN_NONE && (&req_i)) |=> grant_o[PRIO_CH]);
endmodule

// File: rtl/sio_chain_ctrl.sv
module sio_chain_ctrl
   import sio_chain_pkg::*;
#(
   parameter int REG_W   = 8,
   parameter int PRIO_CH = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we_i,
   input  logic [REG_W-1:0] cfg_wdata_i,
   output logic [REG_W-1:0] cfg_rdata_o,
   output logic             cfg_err_o,
   input  logic [1:0]       en_i,
   input  logic [1:0]       busy_i,
   input  logic [1:0]       done_i,
   output logic [1:0]       go_o,
   output logic             chained_o,
   output logic             pin_sel_o
);
   localparam int MODE_W = 2;

   logic           chained;
   logic           held;
   logic           sel;
   logic [NCH-1:0] grant;
   logic           lock;

   assign lock = (|busy_i) | held;

   sio_chain_mode_reg #(.REG_W(REG_W), .MODE_W(MODE_W)) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_i      (cfg_we_i),
      .wdata_i   (cfg_wdata_i),
      .lock_i    (lock),
      .rdata_o   (cfg_rdata_o),
      .err_o     (cfg_err_o),
      .chained_o (chained)
   );

   sio_chain_arbiter #(.PRIO_CH(PRIO_CH)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (chained),
      .req_i    (en_i),
      .done_i   (done_i),
      .grant_o  (grant),
      .held_o   (held),
      .sel_o    (sel)
   );

   assign go_o      = chained ? grant : en_i;
   assign pin_sel_o = chained & sel;
   assign chained_o = chained;

   // R6: one owner at most on the shared pins
   assert_single_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
      chained_o |-> $onehot0(go_o));
   // R10: pin select only points at a granted channel
   assert_sel_granted_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pin_sel_o |-> go_o[1]);
endmodule

// File: tb/sio_chain_ctrl_bench.sv
module sio_chain_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       cfg_err;
   logic [1:0] en = '0, busy = '0, done = '0;
   logic [1:0] go;
   logic       chained, pin_sel;

   int n_run = 0, n_fail = 0;

   always #2 clk = ~clk;

   sio_chain_ctrl u_sio_chain_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
      .cfg_rdata_o(cfg_rdata), .cfg_err_o(cfg_err), .en_i(en), .busy_i(busy),
      .done_i(done), .go_o(go), .chained_o(chained), .pin_sel_o(pin_sel));

   // chained-mode sequence: {en, done, expected go, expected pin_sel}
   localparam int NV = 10;
   localparam logic [6:0] VEC [NV] = '{
      {2'b00, 2'b00, 2'b00, 1'b0},  // idle stays idle
      {2'b11, 2'b00, 2'b01, 1'b0},  // R8 both raised, ch0 first
      {2'b11, 2'b00, 2'b01, 1'b0},  // ch1 waits
      {2'b10, 2'b01, 2'b10, 1'b1},  // R9 hand-off to ch1
      {2'b10, 2'b00, 2'b10, 1'b1},  // R10 ch1 holds pins
      {2'b01, 2'b10, 2'b01, 1'b0},  // R9 hand-off back to ch0
      {2'b01, 2'b10, 2'b01, 1'b0},  // R11 done from non-owner ignored
      {2'b00, 2'b01, 2'b00, 1'b0},  // R11 release
      {2'b10, 2'b00, 2'b10, 1'b1},  // R7 single request granted
      {2'b00, 2'b10, 2'b00, 1'b0}   // R11 release from ch1
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      cfg_we = 1'b1; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rdata", cfg_rdata, 8'hFC);
      chk("R1 go", go, 2'b00);
      chk("R1 err", cfg_err, 0);
      chk("R1 chained", chained, 0);
      chk("R1 sel", pin_sel, 0);

      // R5 split mode pass-through, same cycle
      en = 2'b10; #1;
      chk("R5 go", go, 2'b10);
      chk("R5 sel", pin_sel, 0);
      en = 2'b11; #1;
      chk("R5 go both", go, 2'b11);
      en = 2'b00;
      @(negedge clk);

      // R2 / R3 decode
      wr(8'h02);
      chk("R2 rdata 02", cfg_rdata, 8'hFE);
      chk("R3 code10", chained, 0);
      wr(8'h03);
      chk("R2 rdata 03", cfg_rdata, 8'hFF);
      chk("R3 code11", chained, 0);
      wr(8'h01);
      chk("R2 rdata 01", cfg_rdata, 8'hFD);
      chk("R3 code01", chained, 1);

      // chained sequence table
      for (int i = 0; i < NV; i++) begin
         en = VEC[i][6:5]; done = VEC[i][4:3];
         @(negedge clk);
         chk($sformatf("R9 vec%0d go", i), go, VEC[i][2:1]);
         chk($sformatf("R10 vec%0d sel", i), pin_sel, VEC[i][0]);
      end
      en = '0; done = '0;
      @(negedge clk);

      // R4 lock by grant
      en = 2'b01;
      @(negedge clk);
      en = 2'b00;
      wr(8'h00);
      chk("R4 grant lock rdata", cfg_rdata, 8'hFD);
      chk("R4 grant lock err", cfg_err, 1);
      done = 2'b01;
      @(negedge clk);
      done = 2'b00;
      chk("R11 back to idle", go, 2'b00);

      // R4 lock by busy
      busy = 2'b10;
      wr(8'h00);
      chk("R4 busy lock rdata", cfg_rdata, 8'hFD);
      busy = 2'b00;
      wr(8'h00);
      chk("R4 accepted write", cfg_rdata, 8'hFC);
      chk("R4 err sticky", cfg_err, 1);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule